// File: doc/BRIEF.md
# Radio Command Strobe Sequencer

This block runs a short byte-coded program out of a small local program store and turns it into single-cycle command pulses for a radio controller: receiver on, transmitter on (with or without a clear-channel check), RF off, buffer flushes, acknowledge control and receive-enable bit control. The program can count with three 8-bit registers (X, Y, Z), branch by skipping instructions or by looping back to a label under control of an external condition vector, load X from an external random byte, and stall on timer overflow pulses or on one of two timer events. It can also raise an interrupt pulse and a pulse that asks the timer to latch its compare value.

A host feeds the block through one byte channel with a valid/ready handshake. A byte sent with `host_imm` low is appended to the program store. That is only allowed while the sequencer is stopped and the store has room: otherwise `host_ready` stays low and the host must hold the byte until it is taken. A byte sent with `host_imm` high is an immediate command. It is always accepted in the cycle it is offered and acts at once, whatever the program is doing. Immediate commands can start the program, stop it, clear it, or fire any strobe directly.

Top module: `strobe_seq`

## Requirements
- R1: After reset the sequencer is stopped, X, Y and Z read 0, all pulse outputs are low, the program store is empty and `host_ready` is high.
- R2: Bytes 0xC0/0xC1/0xC2 add one to X/Y/Z and 0xC3/0xC4/0xC5 subtract one, wrapping modulo 256. 0xC8+M (M in 0..7) adds one to Y when Y is below M and otherwise sets Y to M.
- R3: Byte 0xBD copies `rnd_in` into X.
- R4: A byte with bit 7 clear is a skip with span S = bits 6:4, invert N = bit 3 and select C = bits 2:0. When `cond_in[C]` XOR N is 1, the next S program bytes are passed over; otherwise execution continues with the next byte.
- R5: Byte 0xBB records the address after itself as the loop label (start resets the label to 0). A byte 0xA0+N*8+C jumps to the label when `cond_in[C]` XOR N is 1, and falls through otherwise.
- R6: Byte 0x80+W (W in 0..31) stalls until W rising cycles of `tmr_ovf` have been seen after it issues, and 0xBC does the same for the current value of X. A count of zero does not stall. The next instruction issues at the first clock edge after the edge that samples the final pulse.
- R7: Bytes 0xB8 and 0xB9 stall until `tmr_evt1` or `tmr_evt2` respectively is sampled high, and the other timer inputs are ignored while they wait.
- R8: Program bytes 0xD3..0xDF drive one-cycle pulses on `strobe` with the bit mapping low nibble 3→bit0 (RX on), 9→bit1 (TX on), A→bit2 (TX on if clear), B→bit3 (sample CCA), F→bit4 (RF off), D→bit5 (flush RX), E→bit6 (flush TX), 6→bit7 (ack), 7→bit8 (ack with pending), 8→bit9 (abort ack), 4→bit10 (set RX enable bit), 5→bit11 (clear RX enable bit). 0xBA pulses `irq_pulse` and 0xBE pulses `cmp_set_pulse`.
- R9: An immediate byte 0xE3..0xEF pulses the same strobe bit as its 0xD_ counterpart in the cycle after acceptance. 0xE1 starts the program from address 0, 0xE2 stops it, and 0xFF empties the store and stops. All other immediate bytes (such as 0xE0, 0xEC and 0xF0..0xFE) have no effect, and immediate bytes are always accepted.
- R10: Program bytes are accepted only while stopped and while fewer than DEPTH (24) bytes are stored, and each accepted byte is appended after the previous ones.
- R11: One instruction issues per clock outside waits. After a start accepted at edge P, instruction k issues at edge P+1+k and its effect is visible after that edge. Byte 0xD2, or reaching the end of the written bytes, stops execution. The end check costs one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host byte offered |
| host_ready | output | 1 | Host byte taken at this edge if valid |
| host_imm | input | 1 | 1: immediate command, 0: program byte |
| host_data | input | 8 | Host byte |
| cond_in | input | 8 | Condition vector for skips and repeats |
| rnd_in | input | 8 | External random byte |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tmr_evt1 | input | 1 | Timer event 1 |
| tmr_evt2 | input | 1 | Timer event 2 |
| strobe | output | 12 | One-cycle radio command pulses |
| irq_pulse | output | 1 | Interrupt pulse |
| cmp_set_pulse | output | 1 | Request to latch timer compare value |
| running | output | 1 | Program execution active |
| cnt_x | output | 8 | Register X |
| cnt_y | output | 8 | Register Y |
| cnt_z | output | 8 | Register Z |

## Verification
An immediate command shows on the outputs one edge after it is accepted, and program instruction k shows one edge after start-plus-k. A wait releases one edge after its final input pulse is sampled. The run flag falls one edge after the last byte, or at the stop byte itself. The bench counts edges from the accepting handshake and samples on the falling edge that follows the edge where each result is due, and it checks the edge before as well where a pulse must not come early. Random counter programs are compared with a bench model at the exact edge where the run flag drops.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;
  localparam int STB_W = 12;

  typedef enum logic [1:0] {WK_NONE, WK_OVF, WK_EV1, WK_EV2} wait_kind_t;

  localparam logic [7:0] OP_RND   = 8'hBD;
  localparam logic [7:0] OP_WAITX = 8'hBC;
  localparam logic [7:0] OP_EV1   = 8'hB8;
  localparam logic [7:0] OP_EV2   = 8'hB9;
  localparam logic [7:0] OP_IRQ   = 8'hBA;
  localparam logic [7:0] OP_LABEL = 8'hBB;
  localparam logic [7:0] OP_CMP   = 8'hBE;
  localparam logic [7:0] OP_HALT  = 8'hD2;
  localparam logic [7:0] IM_START = 8'hE1;
  localparam logic [7:0] IM_STOP  = 8'hE2;
  localparam logic [7:0] IM_CLEAR = 8'hFF;

  // low nibble of a strobe opcode -> one-hot strobe vector
  function automatic logic [STB_W-1:0] strobe_map(input logic [3:0] nib);
    logic [STB_W-1:0] v;
    v = '0;
    case (nib)
      4'h3: v[0]  = 1'b1;
      4'h9: v[1]  = 1'b1;
      4'hA: v[2]  = 1'b1;
      4'hB: v[3]  = 1'b1;
      4'hF: v[4]  = 1'b1;
      4'hD: v[5]  = 1'b1;
      4'hE: v[6]  = 1'b1;
      4'h6: v[7]  = 1'b1;
      4'h7: v[8]  = 1'b1;
      4'h8: v[9]  = 1'b1;
      4'h4: v[10] = 1'b1;
      4'h5: v[11] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/seq_prog_store.sv
module seq_prog_store #(
  parameter int DEPTH = 24,
  parameter int PCW   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [7:0]                   wr_data,
  input  logic [PCW-1:0]               rd_addr,
  output logic [7:0]                   rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   wr_count,
  output logic                         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_en && !full) begin
      mem[wr_count[AW-1:0]] <= wr_data;
      wr_count <= wr_count + CW'(1);
    end
  end

  assign full    = (wr_count == CW'(DEPTH));
  assign rd_data = (rd_addr < PCW'(DEPTH)) ? mem[rd_addr[AW-1:0]] : 8'h00;
endmodule

// File: rtl/seq_waiter.sv
module seq_waiter
  import strobe_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cancel,
  input  logic       arm,
  input  wait_kind_t arm_kind,
  input  logic [7:0] arm_count,
  input  logic       tmr_ovf,
  input  logic       tmr_evt1,
  input  logic       tmr_evt2,
  output logic       busy
);
  wait_kind_t kind;
  logic [7:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n || cancel) begin
      busy <= 1'b0;
      kind <= WK_NONE;
      left <= 8'd0;
    end else if (arm) begin
      busy <= 1'b1;
      kind <= arm_kind;
      left <= arm_count;
    end else if (busy) begin
      case (kind)
        WK_OVF: if (tmr_ovf) begin
          left <= left - 8'd1;
          if (left == 8'd1) busy <= 1'b0;
        end
        WK_EV1: if (tmr_evt1) busy <= 1'b0;
        WK_EV2: if (tmr_evt2) busy <= 1'b0;
        default: busy <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_seq_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_imm,
  input  logic [7:0]       host_data,
  input  logic [7:0]       cond_in,
  input  logic [7:0]       rnd_in,
  input  logic             tmr_ovf,
  input  logic             tmr_evt1,
  input  logic             tmr_evt2,
  output logic [STB_W-1:0] strobe,
  output logic             irq_pulse,
  output logic             cmp_set_pulse,
  output logic             running,
  output logic [7:0]       cnt_x,
  output logic [7:0]       cnt_y,
  output logic [7:0]       cnt_z
);
  localparam int PCW = $clog2(DEPTH + 9);
  localparam int CW  = $clog2(DEPTH + 1);

  logic [PCW-1:0] pc, label, npc, nlabel;
  logic [7:0]     op, nx, ny, nz;
  logic [CW-1:0]  wr_count;
  logic           full, wait_busy, at_end, issue, nrun;
  logic           host_fire, imm_fire, imm_start, imm_stop, imm_clr;
  logic [STB_W-1:0] stb_prog, stb_imm;
  logic           irq_n, cmp_n, arm;
  wait_kind_t     arm_kind;
  logic [7:0]     arm_cnt;

  assign host_ready = host_imm | (~running & ~full);
  assign host_fire  = host_valid & host_ready;
  assign imm_fire   = host_fire & host_imm;
  assign imm_start  = imm_fire && host_data == IM_START;
  assign imm_stop   = imm_fire && host_data == IM_STOP;
  assign imm_clr    = imm_fire && host_data == IM_CLEAR;
  assign stb_imm    = (imm_fire && host_data[7:4] == 4'hE) ? strobe_map(host_data[3:0]) : '0;

  seq_prog_store #(.DEPTH(DEPTH), .PCW(PCW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(imm_clr),
    .wr_en(host_fire & ~host_imm), .wr_data(host_data),
    .rd_addr(pc), .rd_data(op), .wr_count(wr_count), .full(full)
  );

  seq_waiter u_wait (
    .clk(clk), .rst_n(rst_n), .cancel(imm_start | imm_stop | imm_clr),
    .arm(arm), .arm_kind(arm_kind), .arm_count(arm_cnt),
    .tmr_ovf(tmr_ovf), .tmr_evt1(tmr_evt1), .tmr_evt2(tmr_evt2),
    .busy(wait_busy)
  );

  assign at_end = pc >= {{(PCW-CW){1'b0}}, wr_count};
  assign issue  = running & ~wait_busy & ~at_end;

  always_comb begin
    nx = cnt_x; ny = cnt_y; nz = cnt_z;
    npc = pc; nlabel = label; nrun = running;
    stb_prog = '0; irq_n = 1'b0; cmp_n = 1'b0;
    arm = 1'b0; arm_kind = WK_NONE; arm_cnt = 8'd0;
    if (running && !wait_busy && at_end) begin
      nrun = 1'b0;
    end else if (issue) begin
      npc = pc + PCW'(1);
      if (!op[7]) begin
        if (cond_in[op[2:0]] ^ op[3])
          npc = pc + {{(PCW-3){1'b0}}, op[6:4]} + PCW'(1);
      end else if (op[7:5] == 3'b100) begin
        arm = (op[4:0] != 5'd0); arm_kind = WK_OVF; arm_cnt = {3'b000, op[4:0]};
      end else if (op[7:4] == 4'hA) begin
        if (cond_in[op[2:0]] ^ op[3]) npc = label;
      end else if (op[7:3] == 5'b11001) begin
        if (cnt_y >= {5'd0, op[2:0]}) ny = {5'd0, op[2:0]};
        else ny = cnt_y + 8'd1;
      end else if (op[7:4] == 4'hD) begin
        if (op == OP_HALT) nrun = 1'b0;
        else stb_prog = strobe_map(op[3:0]);
      end else begin
        case (op)
          8'hC0: nx = cnt_x + 8'd1;
          8'hC1: ny = cnt_y + 8'd1;
          8'hC2: nz = cnt_z + 8'd1;
          8'hC3: nx = cnt_x - 8'd1;
          8'hC4: ny = cnt_y - 8'd1;
          8'hC5: nz = cnt_z - 8'd1;
          OP_RND:   nx = rnd_in;
          OP_WAITX: begin arm = (cnt_x != 8'd0); arm_kind = WK_OVF; arm_cnt = cnt_x; end
          OP_EV1:   begin arm = 1'b1; arm_kind = WK_EV1; end
          OP_EV2:   begin arm = 1'b1; arm_kind = WK_EV2; end
          OP_IRQ:   irq_n = 1'b1;
          OP_CMP:   cmp_n = 1'b1;
          OP_LABEL: nlabel = pc + PCW'(1);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; pc <= '0; label <= '0;
      cnt_x <= 8'd0; cnt_y <= 8'd0; cnt_z <= 8'd0;
      strobe <= '0; irq_pulse <= 1'b0; cmp_set_pulse <= 1'b0;
    end else begin
      cnt_x <= nx; cnt_y <= ny; cnt_z <= nz;
      strobe <= stb_prog | stb_imm;
      irq_pulse <= irq_n;
      cmp_set_pulse <= cmp_n;
      pc <= npc; label <= nlabel; running <= nrun;
      if (imm_clr || imm_start) begin
        pc <= '0; label <= '0; running <= imm_start;
      end else if (imm_stop) begin
        running <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_valid,
  input logic       host_ready,
  input logic       host_imm,
  input logic [7:0] host_data,
  input logic       running,
  input logic [7:0] cnt_x,
  input logic [7:0] cnt_y,
  input logic       issue,
  input logic [7:0] op
);
  logic imm_acc;
  assign imm_acc = host_valid & host_ready & host_imm;

  a_r9_imm_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_imm |-> host_ready);

  a_r10_no_write_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    running && host_valid && !host_imm |-> !host_ready);

  a_r9_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
    imm_acc && host_data == 8'hE1 |=> running);

  a_r9_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    imm_acc && (host_data == 8'hE2 || host_data == 8'hFF) |=> !running);

  a_r11_halt_op: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op == 8'hD2 && !(imm_acc && host_data == 8'hE1) |=> !running);

  a_r2_inc_x: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op == 8'hC0 |=> cnt_x == $past(cnt_x) + 8'd1);

  a_r2_clamp_y: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op[7:3] == 5'b11001 |=> cnt_y <= {5'd0, $past(op[2:0])});
endmodule

bind strobe_seq strobe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
  .host_imm(host_imm), .host_data(host_data), .running(running),
  .cnt_x(cnt_x), .cnt_y(cnt_y), .issue(issue), .op(op)
);

// File: tb/strobe_seq_test.sv
module strobe_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 1'b0, host_imm = 1'b0;
  logic [7:0] host_data = 8'h00, cond_in = 8'h00, rnd_in = 8'h00;
  logic tmr_ovf = 1'b0, tmr_evt1 = 1'b0, tmr_evt2 = 1'b0;
  logic host_ready, irq_pulse, cmp_set_pulse, running;
  logic [11:0] strobe;
  logic [7:0] cnt_x, cnt_y, cnt_z;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] prog [32];
  int plen;

  always #10 clk = ~clk;

  strobe_seq uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_mask(input logic [3:0] nib);
    case (nib)
      4'h3: return 12'h001; 4'h9: return 12'h002; 4'hA: return 12'h004;
      4'hB: return 12'h008; 4'hF: return 12'h010; 4'hD: return 12'h020;
      4'hE: return 12'h040; 4'h6: return 12'h080; 4'h7: return 12'h100;
      4'h8: return 12'h200; 4'h4: return 12'h400; 4'h5: return 12'h800;
      default: return 12'h000;
    endcase
  endfunction

  function automatic void model_op(input logic [7:0] op, inout logic [7:0] x, inout logic [7:0] y,
                                   inout logic [7:0] z);
    case (op)
      8'hC0: x = x + 8'd1; 8'hC1: y = y + 8'd1; 8'hC2: z = z + 8'd1;
      8'hC3: x = x - 8'd1; 8'hC4: y = y - 8'd1; 8'hC5: z = z - 8'd1;
      default: if (op[7:3] == 5'b11001) y = (y >= {5'd0, op[2:0]}) ? {5'd0, op[2:0]} : y + 8'd1;
    endcase
  endfunction

  task automatic send(input logic imm, input logic [7:0] d, output bit acc);
    @(negedge clk);
    host_valid = 1'b1; host_imm = imm; host_data = d;
    #1 acc = host_ready;
    @(posedge clk);
    #1 host_valid = 1'b0;
  endtask

  task automatic load_prog();
    bit a;
    send(1'b1, 8'hFF, a);
    for (int i = 0; i < plen; i++) send(1'b0, prog[i], a);
  endtask

  task automatic start();
    bit a;
    send(1'b1, 8'hE1, a);
  endtask

  task automatic pulse_ovf();
    @(negedge clk) tmr_ovf = 1'b1;
    @(negedge clk) tmr_ovf = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] ex, ey, ez, x0, r;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!running && strobe == 0 && !irq_pulse && !cmp_set_pulse, "R1 idle outputs", {running, strobe}, 0);
    chk(cnt_x == 0 && cnt_y == 0 && cnt_z == 0, "R1 counters", {cnt_x, cnt_y, cnt_z}, 0);
    chk(host_ready, "R1 ready", host_ready, 1);

    // R8/R11 program strobes with halt
    plen = 5; prog[0] = 8'hD3; prog[1] = 8'hD9; prog[2] = 8'hDF; prog[3] = 8'hD2; prog[4] = 8'hD6;
    load_prog(); start();
    @(posedge clk); @(negedge clk);
    chk(strobe == 12'h001, "R8 RX on k0", strobe, 12'h001);
    @(negedge clk); chk(strobe == 12'h002, "R8 TX on k1", strobe, 12'h002);
    @(negedge clk); chk(strobe == 12'h010, "R8 RF off k2", strobe, 12'h010);
    @(negedge clk); chk(strobe == 0 && !running, "R11 halt byte", {running, strobe}, 0);
    @(negedge clk); chk(strobe == 0, "R11 no strobe after halt", strobe, 0);

    // R9 immediate strobes
    for (int n = 3; n < 16; n++) begin
      if (n == 12) continue;
      send(1'b1, {4'hE, 4'(n)}, a);
      @(negedge clk);
      chk(a && strobe == exp_mask(4'(n)), "R9 immediate strobe", strobe, exp_mask(4'(n)));
    end
    for (int i = 0; i < 12; i++) begin
      r = (i % 2 == 0) ? {4'hF, 4'($urandom_range(0, 14))} : 8'hE0;
      if (i == 5) r = 8'hEC;
      send(1'b1, r, a);
      @(negedge clk);
      chk(strobe == 0 && !running, "R9 ignored immediate", {running, strobe}, 0);
    end

    // R2/R11 random counter programs against model
    for (int round = 0; round < 10; round++) begin
      plen = (round == 0) ? 24 : $urandom_range(1, 24);
      for (int i = 0; i < plen; i++) begin
        int k = $urandom_range(0, 7);
        prog[i] = (k < 6) ? 8'hC0 + 8'(k) : (k == 6) ? {5'b11001, 3'($urandom_range(0, 7))} : 8'hD0;
      end
      load_prog();
      if (round == 0) begin
        send(1'b0, 8'hD0, a);
        chk(!a, "R10 full store refuses", a, 0);
      end
      ex = cnt_x; ey = cnt_y; ez = cnt_z;
      for (int i = 0; i < plen; i++) model_op(prog[i], ex, ey, ez);
      start();
      repeat (plen) @(posedge clk);
      @(negedge clk);
      chk(running, "R11 still running at last byte", running, 1);
      @(negedge clk);
      chk(!running, "R11 end of bytes stops", running, 0);
      chk(cnt_x == ex && cnt_y == ey && cnt_z == ez, "R2 counter model", {cnt_x, cnt_y, cnt_z}, {ex, ey, ez});
    end

    // R4 skip
    for (int t = 0; t < 3; t++) begin
      plen = 5; prog[0] = (t == 2) ? 8'h2B : 8'h23; prog[1] = 8'hC0; prog[2] = 8'hC0;
      prog[3] = 8'hC1; prog[4] = 8'hD2;
      cond_in = (t == 1) ? 8'h00 : 8'h08;
      load_prog(); x0 = cnt_x; ey = cnt_y + 8'd1;
      start(); repeat (8) @(negedge clk);
      ex = (t == 0) ? x0 : x0 + 8'd2;
      chk(cnt_x == ex && cnt_y == ey, "R4 skip", {cnt_x, cnt_y}, {ex, ey});
    end

    // R5 label and repeat
    plen = 3; prog[0] = 8'hBB; prog[1] = 8'hC0; prog[2] = 8'hA1;
    load_prog(); cond_in = 8'h02; x0 = cnt_x;
    start();
    repeat (6) @(posedge clk);
    @(negedge clk) cond_in = 8'h00;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(!running && cnt_x == x0 + 8'd3, "R5 loop count", {running, cnt_x}, {1'b0, x0 + 8'd3});

    // R6 overflow wait
    plen = 3; prog[0] = 8'h83; prog[1] = 8'hDB; prog[2] = 8'hD2;
    load_prog(); start();
    repeat (3) @(negedge clk);
    chk(running && strobe == 0, "R6 stalled", {running, strobe}, 12'h000 | 13'h1000);
    @(negedge clk) tmr_evt1 = 1'b1;
    @(negedge clk) tmr_evt1 = 1'b0;
    pulse_ovf(); pulse_ovf();
    chk(strobe == 0, "R6 two of three", strobe, 0);
    pulse_ovf();
    chk(strobe == 0, "R6 not early", strobe, 0);
    @(negedge clk);
    chk(strobe == 12'h008, "R6 release edge", strobe, 12'h008);

    // R6 wait for X, X=0 and X=2
    rnd_in = 8'h00;
    plen = 3; prog[0] = 8'hBD; prog[1] = 8'hBC; prog[2] = 8'hD3;
    load_prog(); start();
    repeat (3) @(posedge clk); @(negedge clk);
    chk(strobe == 12'h001 && cnt_x == 0, "R6 X zero no stall", strobe, 12'h001);
    rnd_in = 8'h02; prog[2] = 8'hD9;
    load_prog(); start();
    repeat (4) @(negedge clk);
    pulse_ovf();
    chk(strobe == 0, "R6 X wait holds", strobe, 0);
    pulse_ovf(); @(negedge clk);
    chk(strobe == 12'h002, "R6 X wait release", strobe, 12'h002);

    // R3 random load
    r = 8'($urandom_range(1, 255)); rnd_in = r;
    plen = 1; prog[0] = 8'hBD;
    load_prog(); start();
    @(posedge clk); @(negedge clk);
    chk(cnt_x == r, "R3 random load", cnt_x, r);

    // R7 event wait, R8 irq/cmp
    plen = 4; prog[0] = 8'hB9; prog[1] = 8'hBA; prog[2] = 8'hBE; prog[3] = 8'hD2;
    load_prog(); start();
    repeat (3) @(negedge clk);
    @(negedge clk) tmr_evt1 = 1'b1;
    @(negedge clk) begin tmr_evt1 = 1'b0; tmr_ovf = 1'b1; end
    @(negedge clk) tmr_ovf = 1'b0;
    chk(running && !irq_pulse, "R7 other inputs ignored", {running, irq_pulse}, 2'b10);
    @(negedge clk) tmr_evt2 = 1'b1;
    @(negedge clk) tmr_evt2 = 1'b0;
    chk(!irq_pulse, "R7 not early", irq_pulse, 0);
    @(negedge clk);
    chk(irq_pulse && !cmp_set_pulse, "R8 irq pulse", {irq_pulse, cmp_set_pulse}, 2'b10);
    @(negedge clk);
    chk(!irq_pulse && cmp_set_pulse, "R8 compare pulse", {irq_pulse, cmp_set_pulse}, 2'b01);

    // R9/R10 stop, write refusal while running
    plen = 3; prog[0] = 8'hBB; prog[1] = 8'hC2; prog[2] = 8'hA8;
    cond_in = 8'h00;
    load_prog(); start();
    repeat (5) @(negedge clk);
    send(1'b0, 8'hD0, a);
    chk(!a, "R10 refused while running", a, 0);
    send(1'b1, 8'hE2, a);
    @(negedge clk);
    ez = cnt_z;
    chk(!running, "R9 stop", running, 0);
    repeat (4) @(negedge clk);
    chk(cnt_z == ez, "R9 stopped holds Z", cnt_z, ez);

    // R9 clear while running
    start();
    repeat (4) @(negedge clk);
    send(1'b1, 8'hFF, a);
    @(negedge clk);
    chk(!running, "R9 clear stops", running, 0);
    send(1'b0, 8'hD3, a);
    chk(a, "R10 write after clear", a, 1);
    start();
    @(posedge clk); @(negedge clk);
    chk(strobe == 12'h001, "R9 cleared store holds one byte", strobe, 12'h001);
    @(negedge clk);
    chk(!running && strobe == 0, "R11 end after single byte", {running, strobe}, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule